// File: doc/BRIEF.md
# Cascadable CAM Cycle Controller

This block models one content-addressable memory device sitting on a synchronous host bus. Every clock edge at which `op` is not a no-operation is one bus cycle. The device holds a small array of keyed entries, each with a data word attached. It also holds a comparand register, a mask register and a segment configuration register. Keys, comparand and mask are wider than the 32-bit bus. A configuration bit chooses whether each transfer takes one bus cycle or two.

When the bus cycle that completes the configured transfer width lands on the comparand or the mask, a masked search runs at once, with no separate command. The result stays in the device. A later read returns either the status word or the data of the winning entry.

Several devices can be chained through a match-flag input and a match-flag output. A registered copy of the active-low cascade-enable input decides whether the result locks the chain. A locked chain lets only the highest-priority matching device drive the bus. In Standard mode, a locked chain with no responder refuses writes until an unlocking no-operation cycle occurs. In Enhanced mode, writes pass through a locked chain. With cascade-enable held high, the gating is bypassed and one device can always be reached.

Top module: `cam_cascade_ctl`

## Requirements
- R1: The configuration bit `wdata[0]` of an `op`=3 write picks the transfer width. With 0, each comparand, mask or entry write is a complete transfer that loads key bits [31:0]. With 1, two writes make a transfer: the first loads bits [31:0] and the second loads bits [63:32].
- R2: A write that completes a comparand or mask transfer starts a search using the updated register values. `match_any`, `multi_match` and `mf_out` show that result from the next clock edge on, and they change only when another search runs.
- R3: An entry matches when it is valid and (key XOR comparand) AND NOT mask is zero. `multi_match` is 1 when two or more entries match. The winner is the matching entry with the lowest index.
- R4: One shared segment counter advances on comparand, mask and entry writes. It returns to segment 0 when a transfer completes, and also on any configuration write.
- R5: A read (`op`=6) that is driven returns on the next edge either the status word or the winner's data, as chosen by `sel_stat` (1 = status, 0 = data; the data reads 0 when there is no match). Status bit 0 is match, bit 1 is multi-match, bits 15:8 are the winner index, bit 16 is the lock and bit 17 is Enhanced mode. All other bits are 0.
- R6: A search that completes while `ec_n` is 0 locks the device. While it is locked, a read drives (`rd_oe`=1) only if the device matched and `mf_in` is 0. When `rd_oe` is 0, `rd_data` is 0.
- R7: In Standard mode (configuration bit `wdata[1]`=0), a locked device that is not responding ignores every write. Its lock stays set until a no-operation cycle (`op`=0) with `ec_n` at 1 clears it.
- R8: In Enhanced mode (configuration bit `wdata[1]`=1), writes are accepted while the device is locked.
- R9: A search that completes while `ec_n` is 1 leaves the device unlocked. Reads are then always driven, whatever the match result.
- R10: `mf_out` is 1 whenever the stored match result is set or `mf_in` is 1.
- R11: After reset, all outputs are 0, no entry is valid, all registers are 0, the device is unlocked and the mode is Standard with one-cycle transfers.
- R12: Op codes are 0 no-operation, 1 comparand write, 2 mask write, 3 configuration write, 4 entry key write at `idx`, 5 data write at `idx`, 6 read and 7 invalidate at `idx`. The last key write of a transfer makes the entry valid, and invalidate clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 3 | Bus cycle code (R12) |
| ec_n | input | 1 | Active-low cascade enable, sampled each cycle |
| sel_stat | input | 1 | Read select: 1 status word, 0 entry data |
| idx | input | IDX_W | Entry index for key, data and invalidate writes |
| wdata | input | 32 | Write data segment or configuration bits |
| mf_in | input | 1 | Match flag from the higher-priority device |
| mf_out | output | 1 | Match flag to the next device |
| match_any | output | 1 | Stored search result: any match |
| multi_match | output | 1 | Stored search result: two or more matches |
| rd_data | output | 32 | Read data, registered |
| rd_oe | output | 1 | Read data driven |

## Verification
Each bus cycle is retired at one rising edge. Search flags, lock state, configuration and read data are all registered at that edge, and `mf_out` follows combinationally from the registered match. So every result of a cycle is due exactly one edge after the stimulus is applied. The bench applies stimulus on the falling edge and advances its behavioural model of two chained devices at the rising edge. It then compares every output of both devices at the following falling edge. A write that is ignored shows up later through status or data reads, so blocked writes are checked at the ports.

// File: rtl/cam_ctl_pkg.sv
package cam_ctl_pkg;

    localparam int SEG_W = 32;

    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_CMP = 3'd1,
        OP_MSK = 3'd2,
        OP_CFG = 3'd3,
        OP_ENT = 3'd4,
        OP_ASC = 3'd5,
        OP_RD  = 3'd6,
        OP_INV = 3'd7
    } cam_op_e;

    typedef struct packed {
        logic enh;
        logic wide;
    } cam_cfg_t;

    typedef struct packed {
        logic       hit;
        logic       multi;
        logic [7:0] idx;
    } cam_res_t;

    function automatic logic op_writes(cam_op_e o);
        return (o == OP_CMP) || (o == OP_MSK) || (o == OP_CFG) ||
               (o == OP_ENT) || (o == OP_ASC) || (o == OP_INV);
    endfunction

    function automatic logic [SEG_W-1:0] pack_status(cam_res_t r, logic lk, logic enh);
        return {14'd0, enh, lk, r.idx, 6'd0, r.multi, r.hit};
    endfunction

endpackage

// File: rtl/cam_seg_ctr.sv
module cam_seg_ctr #(
    parameter int NSEG = 2,
    localparam int CW = (NSEG > 1) ? $clog2(NSEG) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic          clr,
    input  logic          wide,
    output logic [CW-1:0] cnt,
    output logic          last
);
    logic [CW-1:0] end_cnt;

    assign end_cnt = wide ? CW'(NSEG - 1) : '0;
    assign last    = (cnt == end_cnt);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (adv)
            cnt <= last ? '0 : cnt + 1'b1;
    end

    // R4
    seg_range_chk: assert property (@(posedge clk) disable iff (rst) cnt <= end_cnt);
    // R4
    seg_clr_chk: assert property (@(posedge clk) disable iff (rst) clr |=> cnt == '0);
endmodule

// File: rtl/cam_entry_store.sv
module cam_entry_store
    import cam_ctl_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int KEY_W   = 64,
    parameter int ASSOC_W = 32,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int NSEG   = KEY_W / SEG_W,
    localparam int CW     = (NSEG > 1) ? $clog2(NSEG) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_cmp,
    input  logic               wr_msk,
    input  logic               wr_ent,
    input  logic               wr_asc,
    input  logic               wr_inv,
    input  logic               last,
    input  logic [CW-1:0]      seg,
    input  logic [IDX_W-1:0]   idx,
    input  logic [IDX_W-1:0]   rd_idx,
    input  logic [SEG_W-1:0]   wdata,
    output cam_res_t           res,
    output logic [ASSOC_W-1:0] assoc_rd
);
    logic [KEY_W-1:0]   cmp_q, msk_q, cmp_nx, msk_nx;
    logic [KEY_W-1:0]   key_q [ENTRIES];
    logic [ASSOC_W-1:0] asc_q [ENTRIES];
    logic [ENTRIES-1:0] vld_q;
    logic [ENTRIES-1:0] hit_v;

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        assign cmp_nx[s*SEG_W +: SEG_W] = (wr_cmp && seg == CW'(s)) ? wdata : cmp_q[s*SEG_W +: SEG_W];
        assign msk_nx[s*SEG_W +: SEG_W] = (wr_msk && seg == CW'(s)) ? wdata : msk_q[s*SEG_W +: SEG_W];
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        assign hit_v[e] = vld_q[e] && (((key_q[e] ^ cmp_nx) & ~msk_nx) == '0);
    end

    always_comb begin
        res = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (hit_v[e]) begin
                if (res.hit)
                    res.multi = 1'b1;
                else begin
                    res.hit = 1'b1;
                    res.idx = 8'(e);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '0;
            msk_q <= '0;
            vld_q <= '0;
            for (int e = 0; e < ENTRIES; e++) begin
                key_q[e] <= '0;
                asc_q[e] <= '0;
            end
        end else begin
            cmp_q <= cmp_nx;
            msk_q <= msk_nx;
            if (wr_ent) begin
                key_q[idx][int'(seg)*SEG_W +: SEG_W] <= wdata;
                if (last)
                    vld_q[idx] <= 1'b1;
            end
            if (wr_asc)
                asc_q[idx] <= ASSOC_W'(wdata);
            if (wr_inv)
                vld_q[idx] <= 1'b0;
        end
    end

    assign assoc_rd = asc_q[rd_idx];

    // R12
    inv_clear_chk: assert property (@(posedge clk) disable iff (rst) wr_inv |=> !vld_q[$past(idx)]);

    if (NSEG > 1) begin : g_upper_chk
        // R1
        low_seg_keep_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_cmp && seg == '0) |=> cmp_q[KEY_W-1:SEG_W] == $past(cmp_q[KEY_W-1:SEG_W]));
    end
endmodule

// File: rtl/cam_chain_ctl.sv
module cam_chain_ctl (
    input  logic clk,
    input  logic rst,
    input  logic cmp_fire,
    input  logic ec_n,
    input  logic nop,
    input  logic enh,
    input  logic match_q,
    input  logic mf_in,
    output logic lk,
    output logic resp,
    output logic wr_ok,
    output logic mf_out
);
    assign resp   = match_q & ~mf_in;
    assign wr_ok  = ~(lk & ~enh & ~resp);
    assign mf_out = match_q | mf_in;

    always_ff @(posedge clk) begin
        if (rst)
            lk <= 1'b0;
        else if (cmp_fire)
            lk <= ~ec_n;
        else if (nop && ec_n)
            lk <= 1'b0;
    end

    // R10
    mf_pass_chk: assert property (@(posedge clk) disable iff (rst) mf_in |-> mf_out);
    // R9
    no_lock_chk: assert property (@(posedge clk) disable iff (rst) (cmp_fire && ec_n) |=> !lk);
    // R7
    unlock_chk: assert property (@(posedge clk) disable iff (rst) (nop && ec_n) |=> !lk);
endmodule

// File: rtl/cam_cascade_ctl.sv
module cam_cascade_ctl
    import cam_ctl_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int KEY_W   = 64,
    parameter int ASSOC_W = 32,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int NSEG   = KEY_W / SEG_W,
    localparam int CW     = (NSEG > 1) ? $clog2(NSEG) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       op,
    input  logic             ec_n,
    input  logic             sel_stat,
    input  logic [IDX_W-1:0] idx,
    input  logic [SEG_W-1:0] wdata,
    input  logic             mf_in,
    output logic             mf_out,
    output logic             match_any,
    output logic             multi_match,
    output logic [SEG_W-1:0] rd_data,
    output logic             rd_oe
);
    cam_op_e            op_e;
    cam_cfg_t           cfg_q;
    cam_res_t           res, res_q;
    logic               lk, resp, wr_ok, acc;
    logic               wr_cmp, wr_msk, wr_cfg, wr_ent, wr_asc, wr_inv;
    logic               last, fire, drive;
    logic [CW-1:0]      seg;
    logic [ASSOC_W-1:0] assoc_rd;
    logic [SEG_W-1:0]   rd_nx;

    assign op_e   = cam_op_e'(op);
    assign acc    = op_writes(op_e) & wr_ok;
    assign wr_cmp = acc && op_e == OP_CMP;
    assign wr_msk = acc && op_e == OP_MSK;
    assign wr_cfg = acc && op_e == OP_CFG;
    assign wr_ent = acc && op_e == OP_ENT;
    assign wr_asc = acc && op_e == OP_ASC;
    assign wr_inv = acc && op_e == OP_INV;
    assign fire   = (wr_cmp | wr_msk) & last;

    cam_seg_ctr #(.NSEG(NSEG)) u_seg (
        .clk  (clk),
        .rst  (rst),
        .adv  (wr_cmp | wr_msk | wr_ent),
        .clr  (wr_cfg),
        .wide (cfg_q.wide),
        .cnt  (seg),
        .last (last)
    );

    cam_entry_store #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .ASSOC_W(ASSOC_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_cmp   (wr_cmp),
        .wr_msk   (wr_msk),
        .wr_ent   (wr_ent),
        .wr_asc   (wr_asc),
        .wr_inv   (wr_inv),
        .last     (last),
        .seg      (seg),
        .idx      (idx),
        .rd_idx   (IDX_W'(res_q.idx)),
        .wdata    (wdata),
        .res      (res),
        .assoc_rd (assoc_rd)
    );

    cam_chain_ctl u_chain (
        .clk      (clk),
        .rst      (rst),
        .cmp_fire (fire),
        .ec_n     (ec_n),
        .nop      (op_e == OP_NOP),
        .enh      (cfg_q.enh),
        .match_q  (res_q.hit),
        .mf_in    (mf_in),
        .lk       (lk),
        .resp     (resp),
        .wr_ok    (wr_ok),
        .mf_out   (mf_out)
    );

    assign drive = (op_e == OP_RD) && (!lk || resp);

    always_comb begin
        rd_nx = '0;
        if (drive) begin
            if (sel_stat)
                rd_nx = pack_status(res_q, lk, cfg_q.enh);
            else if (res_q.hit)
                rd_nx = SEG_W'(assoc_rd);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            res_q   <= '0;
            rd_data <= '0;
            rd_oe   <= 1'b0;
        end else begin
            if (wr_cfg)
                cfg_q <= '{enh: wdata[1], wide: wdata[0]};
            if (fire)
                res_q <= res;
            rd_data <= rd_nx;
            rd_oe   <= drive;
        end
    end

    assign match_any   = res_q.hit;
    assign multi_match = res_q.multi;

    // R6
    oe_zero_chk: assert property (@(posedge clk) disable iff (rst) !rd_oe |-> rd_data == '0);
    // R6
    lock_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (op_e == OP_RD && lk && !resp) |=> !rd_oe);
    // R7
    std_block_chk: assert property (@(posedge clk) disable iff (rst)
        (op_writes(op_e) && lk && !cfg_q.enh && !resp) |=> ($stable(cfg_q) && $stable(res_q)));
    // R2
    res_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !fire |=> ($stable(match_any) && $stable(multi_match)));
endmodule

// File: tb/tb_cam_cascade_ctl.sv
`timescale 1ns/1ps
module tb_cam_cascade_ctl;
    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  op0, op1;
    logic        ec_n, sel_stat;
    logic [3:0]  idx;
    logic [31:0] wd;
    logic        mf0, mf1, ma0, ma1, mm0, mm1, oe0, oe1;
    logic [31:0] rd0, rd1;

    always #2.5 clk = ~clk;

    cam_cascade_ctl dut (
        .clk(clk), .rst(rst), .op(op0), .ec_n(ec_n), .sel_stat(sel_stat), .idx(idx),
        .wdata(wd), .mf_in(1'b0), .mf_out(mf0), .match_any(ma0), .multi_match(mm0),
        .rd_data(rd0), .rd_oe(oe0));

    cam_cascade_ctl dut1 (
        .clk(clk), .rst(rst), .op(op1), .ec_n(ec_n), .sel_stat(sel_stat), .idx(idx),
        .wdata(wd), .mf_in(mf0), .mf_out(mf1), .match_any(ma1), .multi_match(mm1),
        .rd_data(rd1), .rd_oe(oe1));

    int    n_cmp = 0, n_bad = 0;
    bit    done = 0;
    string req = "R11";

    logic [63:0] mkey [2][16];
    logic [31:0] masc [2][16];
    bit          mvld [2][16];
    logic [63:0] mcmp [2], mmsk [2];
    bit          mwide [2], menh [2], mmatch [2], mmulti [2], mlk [2], moe [2];
    int          mcnt [2], mhidx [2];
    logic [31:0] mdout [2];

    localparam logic [63:0] KA = 64'h1234_5678_9ABC_DEF0;
    localparam logic [63:0] KB = 64'h0F0F_0000_5555_AAAA;
    localparam logic [63:0] KC = 64'hDEAD_BEEF_0000_0001;

    task automatic mreset();
        for (int d = 0; d < 2; d++) begin
            for (int e = 0; e < 16; e++) begin
                mkey[d][e] = '0; masc[d][e] = '0; mvld[d][e] = 0;
            end
            mcmp[d] = '0; mmsk[d] = '0; mwide[d] = 0; menh[d] = 0; mmatch[d] = 0;
            mmulti[d] = 0; mlk[d] = 0; moe[d] = 0; mcnt[d] = 0; mhidx[d] = 0; mdout[d] = '0;
        end
    endtask

    task automatic msearch(input int d);
        int n;
        n = 0; mhidx[d] = 0;
        for (int e = 0; e < 16; e++)
            if (mvld[d][e] && (((mkey[d][e] ^ mcmp[d]) & ~mmsk[d]) == 64'd0)) begin
                if (n == 0) mhidx[d] = e;
                n++;
            end
        mmatch[d] = (n > 0);
        mmulti[d] = (n > 1);
    endtask

    task automatic mdl(input int d, input logic [2:0] o, input bit rsp, input bit ec,
                       input bit ss, input int ix, input logic [31:0] w);
        bit wrop, blk, fin;
        logic [31:0] st;
        wrop = (o != 3'd0) && (o != 3'd6);
        blk  = wrop && mlk[d] && !menh[d] && !rsp;
        st   = (32'(menh[d]) << 17) | (32'(mlk[d]) << 16) | (32'(mhidx[d]) << 8) |
               (32'(mmulti[d]) << 1) | 32'(mmatch[d]);
        moe[d] = 0; mdout[d] = '0;
        if (o == 3'd6) begin
            if (!mlk[d] || rsp) begin
                moe[d] = 1;
                mdout[d] = ss ? st : (mmatch[d] ? masc[d][mhidx[d]] : 32'd0);
            end
        end else if (o == 3'd0) begin
            if (ec) mlk[d] = 0;
        end else if (!blk) begin
            case (o)
                3'd3: begin mwide[d] = w[0]; menh[d] = w[1]; mcnt[d] = 0; end
                3'd5: masc[d][ix] = w;
                3'd7: mvld[d][ix] = 0;
                default: begin
                    fin = (mcnt[d] == (mwide[d] ? 1 : 0));
                    if (o == 3'd1)      mcmp[d][32*mcnt[d] +: 32] = w;
                    else if (o == 3'd2) mmsk[d][32*mcnt[d] +: 32] = w;
                    else                mkey[d][ix][32*mcnt[d] +: 32] = w;
                    mcnt[d] = fin ? 0 : mcnt[d] + 1;
                    if (fin && o == 3'd4) mvld[d][ix] = 1;
                    if (fin && o != 3'd4) begin msearch(d); mlk[d] = !ec; end
                end
            endcase
        end
    endtask

    task automatic chk1(input int d, input logic [31:0] ad, input logic aoe, ama, amm, amf);
        logic [35:0] act, exp_v;
        logic emf;
        emf = (d == 0) ? mmatch[0] : (mmatch[1] | mmatch[0]);
        act   = {ad, aoe, ama, amm, amf};
        exp_v = {mdout[d], moe[d], mmatch[d], mmulti[d], emf};
        n_cmp++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s dev%0d: actual data=%h oe/ma/mm/mf=%b expected data=%h oe/ma/mm/mf=%b",
                     req, d, act[35:4], act[3:0], exp_v[35:4], exp_v[3:0]);
        end
    endtask

    task automatic chk_all();
        chk1(0, rd0, oe0, ma0, mm0, mf0);
        chk1(1, rd1, oe1, ma1, mm1, mf1);
    endtask

    task automatic step(input logic [2:0] o0, o1, input bit ec, input bit ss,
                        input int ix, input logic [31:0] w);
        bit r0, r1;
        op0 = o0; op1 = o1; ec_n = ec; sel_stat = ss; idx = 4'(ix); wd = w;
        @(posedge clk);
        r0 = mmatch[0];
        r1 = mmatch[1] && !mmatch[0];
        mdl(0, o0, r0, ec, ss, ix, w);
        mdl(1, o1, r1, ec, ss, ix, w);
        @(negedge clk);
        chk_all();
    endtask

    task automatic both(input logic [2:0] o, input bit ec, input logic [31:0] w);
        step(o, o, ec, 0, 0, w);
    endtask

    task automatic both64(input logic [2:0] o, input bit ec, input logic [63:0] v);
        step(o, o, ec, 0, 0, v[31:0]);
        step(o, o, ec, 0, 0, v[63:32]);
    endtask

    task automatic load(input int d, input int ix, input logic [63:0] k, input logic [31:0] a);
        logic [2:0] e0, e1, s0, s1;
        e0 = (d == 0) ? 3'd4 : 3'd0; e1 = (d == 1) ? 3'd4 : 3'd0;
        s0 = (d == 0) ? 3'd5 : 3'd0; s1 = (d == 1) ? 3'd5 : 3'd0;
        step(e0, e1, 1, 0, ix, k[31:0]);
        step(e0, e1, 1, 0, ix, k[63:32]);
        step(s0, s1, 1, 0, ix, a);
    endtask

    task automatic reads(input bit ec);
        step(3'd6, 3'd6, ec, 1, 0, 32'd0);
        step(3'd6, 3'd6, ec, 0, 0, 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL %s watchdog: actual=running expected=finished", req);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1; op0 = 0; op1 = 0; ec_n = 1; sel_stat = 0; idx = 0; wd = 0;
        mreset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        req = "R11"; chk_all();
        reads(1);

        req = "R12";
        both(3'd3, 1, 32'd1);
        load(0, 2, KA, 32'hA2);
        load(0, 5, KA, 32'hA5);
        load(1, 1, KB, 32'hB1);
        load(1, 3, KA, 32'hB3);
        load(0, 9, KC ^ 64'h10, 32'hC9);

        req = "R2";  both64(3'd2, 1, 64'd0);
        both64(3'd1, 1, KB);
        req = "R9";  reads(1);
        req = "R5";  reads(1);
        req = "R10"; step(3'd0, 3'd0, 1, 0, 0, 0);

        req = "R6"; both64(3'd1, 0, KA);
        reads(0);
        req = "R3"; step(3'd6, 3'd6, 1, 1, 0, 0);

        req = "R7"; both64(3'd1, 0, KC);
        step(3'd5, 3'd5, 0, 0, 2, 32'hFFFF);
        both64(3'd2, 0, 64'hFFFF_FFFF_FFFF_FFFF);
        reads(0);
        step(3'd0, 3'd0, 0, 0, 0, 0);
        reads(0);
        step(3'd0, 3'd0, 1, 0, 0, 0);
        reads(1);
        both64(3'd1, 1, KA);
        reads(1);

        req = "R3"; both64(3'd2, 1, 64'h10);
        both64(3'd1, 1, KC);
        reads(1);
        both64(3'd2, 1, 64'd0);

        req = "R8"; both(3'd3, 1, 32'd3);
        both64(3'd1, 0, KC);
        step(3'd5, 3'd5, 0, 0, 9, 32'h99);
        reads(0);
        step(3'd0, 3'd0, 1, 0, 0, 0);
        both64(3'd2, 1, 64'h10);
        both64(3'd1, 1, KC);
        reads(1);

        req = "R1"; both(3'd3, 1, 32'd0);
        both(3'd1, 1, KA[31:0]);
        reads(1);
        both(3'd2, 1, 32'hFFFF_FFFF);
        reads(1);

        req = "R4"; both(3'd3, 1, 32'd1);
        both64(3'd2, 1, 64'd0);
        both(3'd1, 1, 32'h0000_DEAD);
        both(3'd3, 1, 32'd1);
        both64(3'd1, 1, KB);
        reads(1);

        req = "R12"; step(3'd0, 3'd7, 1, 0, 1, 0);
        both64(3'd1, 1, KB);
        reads(1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule